// File: doc/BRIEF.md
# SD Host Wrapper Register Block

This block is the shared register front end for a pair of SD host slot controllers. It answers 32-bit reads and writes inside a 4 KB window on an APB-style slave port. The lowest 256 bytes hold global registers: a control and presence word, a debounce setting, a bus setting, write-protect polarity, card detect, and an interrupt status word. Four offsets in that space map onto each slot's capability and maximum-current values. The block holds those values and drives them to the slots.

The next 256-byte pages belong to the slots, one page per slot. An access there is passed through on a downstream port with a one-hot slot select, and read data comes back from that port. The block also samples each slot's interrupt line into the status word and drives one combined interrupt. The slot count parameter (1 or 2) sets which presence bits come up at reset. Status bits, alias registers and windows of a slot that is not fitted read as zero.

Top module: `sdhw_top`

## Requirements
- R1: After synchronous reset the control word at 0x00 reads bit 16 set, bit 17 set only when NUM_SLOTS is 2, and all other bits 0. The debounce word at 0x04 reads 0x00000005. Bus (0x08), polarity (0xEC), card detect (0xF0) and status (0xFC) read 0. irq_out is 0. Each fitted slot's capability reads CAP_RESET and its max-current reads 0.
- R2: A write to 0x00 stores the written word with bit 0 forced to 0, so bit 0 always reads 0.
- R3: Offsets 0x04, 0x08, 0xEC and 0xF0 store a full 32-bit write and return it on later reads.
- R4: Offsets 0x10 and 0x18 are slot 0's capability and max-current. Offsets 0x20 and 0x28 are the same for slot 1. A write updates the value driven on slot_cap or slot_maxcur, lane n being bits [32n+31:32n], and a read returns it.
- R5: Bit n of the status word at 0xFC equals slot_irq[n] as sampled at the previous clock edge. Writes to 0xFC have no effect.
- R6: irq_out is the OR of the status bits, so it changes one clock after a change on slot_irq.
- R7: An access at 0x100*(n+1)+k, with k in 0..0xFF and slot n fitted, asserts only fwd_sel[n]. It presents k on fwd_addr, along with fwd_write, fwd_wdata and fwd_enable. A read returns fwd_rdata with no error.
- R8: An access with pstrb other than 4'b1111 gets pslverr. It returns read data 0, changes no register and selects no slot.
- R9: An access at 0x300 or above gets pslverr. It returns read data 0, changes no register and selects no slot.
- R10: With NUM_SLOTS=1, slot 1's status bit, alias registers, capability and max-current outputs, and window all read 0 without error. Slot 1's interrupt line does not reach irq_out.
- R11: Local offsets below 0x100 that are not named above read 0 without error and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 12 | Byte address in the 4 KB window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte strobes; only 4'b1111 is accepted |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Error response |
| slot_irq | input | 2 | Per-slot interrupt levels |
| irq_out | output | 1 | Combined interrupt |
| slot_cap | output | 64 | Per-slot capability values, 32 bits per lane |
| slot_maxcur | output | 64 | Per-slot max-current values, 32 bits per lane |
| fwd_sel | output | 2 | One-hot slot window select |
| fwd_enable | output | 1 | Access phase toward the slot |
| fwd_write | output | 1 | Write toward the slot |
| fwd_addr | output | 8 | Offset within the slot window |
| fwd_wdata | output | 32 | Write data toward the slot |
| fwd_rdata | input | 32 | Read data from the selected slot |

## Verification
The bench writ all ones to the control word. A design that drops the clear of bit 0 reads back 0xFFFFFFFF. A design that also clears other bits loses the presence bits. Partial-strobe writes and writes above the slot windows are each followed by a read of the target. This catches a block that commits state while it raises the error. Interrupt edges are sampled both before and after the clock that should carry them, so an unregistered or doubly registered status path fails. A second instance built with a single slot shows that an absent slot's window, alias registers, status bit and interrupt stay silent instead of aliasing onto slot 0 or returning an error.

// File: rtl/sdhw_pkg.sv
// Shared constants and types for the SD host wrapper register block.
// Assumes a 32-bit data path and a 4 KB byte-addressed window.
package sdhw_pkg;
    localparam int DW        = 32;
    localparam int AW        = 12;
    localparam int MAX_SLOTS = 2;
    localparam int SW        = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;

    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_DEBN  = 8'h04;
    localparam logic [7:0] OFF_BUSC  = 8'h08;
    localparam logic [7:0] OFF_CAPB  = 8'h10;  // slot n capability at OFF_CAPB + 16*n
    localparam logic [7:0] OFF_MCUR  = 8'h18;  // slot n max-current at OFF_MCUR + 16*n
    localparam logic [7:0] OFF_WPOL  = 8'hEC;
    localparam logic [7:0] OFF_CDET  = 8'hF0;
    localparam logic [7:0] OFF_ISTAT = 8'hFC;

    localparam logic [DW-1:0] DEBN_RESET = 32'h0000_0005;
    localparam int            PRES_BIT0  = 16;

    typedef enum logic [1:0] {
        RG_LOCAL  = 2'd0,
        RG_SLOT   = 2'd1,
        RG_ABSENT = 2'd2,
        RG_BAD    = 2'd3
    } region_e;
endpackage

// File: rtl/sdhw_decode.sv
// Address decoder: sorts a bus address into the local page, a fitted slot page,
// an absent slot page, or out-of-range. It also flags partial-strobe accesses.
// Assumes that pages 1..MAX_SLOTS are slot windows.
module sdhw_decode
    import sdhw_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic [AW-1:0] addr,
    input  logic [3:0]    strb,
    output region_e       region,
    output logic [SW-1:0] slot_idx,
    output logic          partial
);
    logic [3:0] page;
    assign page = addr[AW-1:8];

    // Select the region from the page number.
    always_comb begin
        slot_idx = '0;
        if (page == 4'd0) begin
            region = RG_LOCAL;
        end else if (int'(page) <= MAX_SLOTS) begin
            slot_idx = SW'(page - 4'd1);
            region   = (int'(page) <= NUM_SLOTS) ? RG_SLOT : RG_ABSENT;
        end else begin
            region = RG_BAD;
        end
    end

    // Only full-word accesses are accepted.
    assign partial = (strb != 4'b1111);
endmodule

// File: rtl/sdhw_irq.sv
// Interrupt collector: registers each fitted slot's interrupt level into a status
// vector and ORs it into a single output. Lines of absent slots are masked off.
module sdhw_irq
    import sdhw_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MAX_SLOTS-1:0] slot_irq,
    output logic [MAX_SLOTS-1:0] stat,
    output logic                 irq_out
);
    localparam logic [MAX_SLOTS-1:0] FIT_MASK = MAX_SLOTS'((1 << NUM_SLOTS) - 1);

    logic [MAX_SLOTS-1:0] stat_q;

    // Follow the input levels of the fitted slots, one clock late.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= slot_irq & FIT_MASK;
    end

    assign stat    = stat_q;
    assign irq_out = |stat_q;
endmodule

// File: rtl/sdhw_globals.sv
// Global register file: control/presence, debounce, bus, polarity, card detect,
// and per-slot capability and max-current values. Holds the read mux for the
// local page. A write arrives as a one-cycle qualified strobe with an offset.
module sdhw_globals
    import sdhw_pkg::*;
#(
    parameter int            NUM_SLOTS = 2,
    parameter logic [DW-1:0] CAP_RESET = 32'h0170_00B2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              off,
    input  logic [DW-1:0]           wdata,
    input  logic [MAX_SLOTS-1:0]    irq_stat,
    output logic [DW-1:0]           rdata,
    output logic [MAX_SLOTS*DW-1:0] slot_cap,
    output logic [MAX_SLOTS*DW-1:0] slot_maxcur
);
    // Build the reset value of the control word from the slot count.
    function automatic logic [DW-1:0] ctrl_reset();
        logic [DW-1:0] v = '0;
        for (int n = 0; n < NUM_SLOTS; n++) v[PRES_BIT0 + n] = 1'b1;
        return v;
    endfunction

    localparam logic [DW-1:0] CTRL_RESET = ctrl_reset();

    logic [DW-1:0] ctrl_q, debn_q, busc_q, wpol_q, cdet_q;
    logic [DW-1:0] cap_q [MAX_SLOTS];
    logic [DW-1:0] mcur_q[MAX_SLOTS];

    // Plain global registers; bit 0 of the control word never stores a 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            debn_q <= DEBN_RESET;
            busc_q <= '0;
            wpol_q <= '0;
            cdet_q <= '0;
        end else if (wr_en) begin
            case (off)
                OFF_CTRL: ctrl_q <= {wdata[DW-1:1], 1'b0};
                OFF_DEBN: debn_q <= wdata;
                OFF_BUSC: busc_q <= wdata;
                OFF_WPOL: wpol_q <= wdata;
                OFF_CDET: cdet_q <= wdata;
                default:  ;
            endcase
        end
    end

    for (genvar n = 0; n < MAX_SLOTS; n++) begin : g_slot
        localparam logic [7:0] CAP_OFF = OFF_CAPB + 8'(16 * n);
        localparam logic [7:0] MC_OFF  = OFF_MCUR + 8'(16 * n);
        if (n < NUM_SLOTS) begin : g_fit
            // Per-slot capability and max-current, updated through the alias offsets.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cap_q[n]  <= CAP_RESET;
                    mcur_q[n] <= '0;
                end else if (wr_en && off == CAP_OFF) begin
                    cap_q[n] <= wdata;
                end else if (wr_en && off == MC_OFF) begin
                    mcur_q[n] <= wdata;
                end
            end
        end else begin : g_absent
            assign cap_q[n]  = '0;
            assign mcur_q[n] = '0;
        end
        assign slot_cap[n*DW +: DW]    = cap_q[n];
        assign slot_maxcur[n*DW +: DW] = mcur_q[n];
    end

    // Read mux for the local page; unnamed offsets read zero.
    always_comb begin
        rdata = '0;
        case (off)
            OFF_CTRL:  rdata = ctrl_q;
            OFF_DEBN:  rdata = debn_q;
            OFF_BUSC:  rdata = busc_q;
            OFF_WPOL:  rdata = wpol_q;
            OFF_CDET:  rdata = cdet_q;
            OFF_ISTAT: rdata = DW'(irq_stat);
            default: begin
                for (int n = 0; n < MAX_SLOTS; n++) begin
                    if (off == OFF_CAPB + 8'(16 * n)) rdata = cap_q[n];
                    if (off == OFF_MCUR + 8'(16 * n)) rdata = mcur_q[n];
                end
            end
        endcase
    end
endmodule

// File: rtl/sdhw_top.sv
// SD host wrapper register block top: APB-style zero-wait slave over a 4 KB window.
// The local page goes to the global register file, and slot pages are passed
// through to the slots. Partial-strobe or out-of-range accesses get an error
// response and change nothing. Assumes NUM_SLOTS is 1 or 2.
module sdhw_top
    import sdhw_pkg::*;
#(
    parameter int            NUM_SLOTS = 2,
    parameter logic [31:0]   CAP_RESET = 32'h0170_00B2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    input  logic [3:0]  pstrb,
    output logic [31:0] prdata,
    output logic        pready,
    output logic        pslverr,
    input  logic [1:0]  slot_irq,
    output logic        irq_out,
    output logic [63:0] slot_cap,
    output logic [63:0] slot_maxcur,
    output logic [1:0]  fwd_sel,
    output logic        fwd_enable,
    output logic        fwd_write,
    output logic [7:0]  fwd_addr,
    output logic [31:0] fwd_wdata,
    input  logic [31:0] fwd_rdata
);
    region_e              region;
    logic [SW-1:0]        slot_idx;
    logic                 partial;
    logic [MAX_SLOTS-1:0] irq_stat;
    logic [DW-1:0]        glob_rdata;
    logic                 access, bad, loc_wr;

    sdhw_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
        .addr(paddr), .strb(pstrb), .region(region),
        .slot_idx(slot_idx), .partial(partial)
    );

    sdhw_irq #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
        .clk(clk), .rst_n(rst_n), .slot_irq(slot_irq),
        .stat(irq_stat), .irq_out(irq_out)
    );

    sdhw_globals #(.NUM_SLOTS(NUM_SLOTS), .CAP_RESET(CAP_RESET)) u_glb (
        .clk(clk), .rst_n(rst_n), .wr_en(loc_wr), .off(paddr[7:0]),
        .wdata(pwdata), .irq_stat(irq_stat), .rdata(glob_rdata),
        .slot_cap(slot_cap), .slot_maxcur(slot_maxcur)
    );

    // Access qualification and error response.
    assign access  = psel & penable;
    assign bad     = partial | (region == RG_BAD);
    assign pslverr = access & bad;
    assign pready  = 1'b1;
    assign loc_wr  = access & pwrite & !bad & (region == RG_LOCAL);

    // Slot window pass-through, one-hot by slot.
    for (genvar n = 0; n < MAX_SLOTS; n++) begin : g_fwd
        assign fwd_sel[n] = psel & !partial & (region == RG_SLOT) & (slot_idx == SW'(n));
    end
    assign fwd_enable = penable;
    assign fwd_write  = pwrite;
    assign fwd_addr   = paddr[7:0];
    assign fwd_wdata  = pwdata;

    // Read data source by region; errors and absent slots read zero.
    always_comb begin
        prdata = '0;
        if (access && !bad && !pwrite) begin
            case (region)
                RG_LOCAL: prdata = glob_rdata;
                RG_SLOT:  prdata = fwd_rdata;
                default:  prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sdhw_chk.sv
// Assertion checker for sdhw_top, attached by bind. Observes ports only.
module sdhw_chk #(
    parameter int NUM_SLOTS = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [11:0] paddr,
    input logic [3:0]  pstrb,
    input logic [31:0] prdata,
    input logic        pslverr,
    input logic [1:0]  slot_irq,
    input logic        irq_out,
    input logic [1:0]  fwd_sel
);
    localparam logic [1:0] FIT = 2'((1 << NUM_SLOTS) - 1);

    p_partial_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pstrb != 4'hF) |-> (pslverr && prdata == 32'h0 && fwd_sel == 2'b00));

    p_range_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && paddr >= 12'h300) |-> (pslverr && prdata == 32'h0));

    p_err_nofwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> fwd_sel == 2'b00);

    p_ctrl_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && paddr == 12'h000 && pstrb == 4'hF) |-> !prdata[0]);

    p_irq_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_out == |($past(slot_irq) & FIT)));

    p_fwd_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fwd_sel));
endmodule

bind sdhw_top sdhw_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pstrb(pstrb), .prdata(prdata), .pslverr(pslverr),
    .slot_irq(slot_irq), .irq_out(irq_out), .fwd_sel(fwd_sel)
);

// File: tb/tb_sdhw_top.sv
module tb_sdhw_top;
    localparam logic [31:0] CAPR = 32'h0170_00B2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  pstrb = 4'hF;
    logic [1:0]  slot_irq = 2'b00;
    logic [31:0] fwd_rdata;

    logic [31:0] prdata, prdata1;
    logic        pready, pready1, pslverr, pslverr1, irq_out, irq_out1;
    logic [63:0] slot_cap, slot_cap1, slot_maxcur, slot_maxcur1;
    logic [1:0]  fwd_sel, fwd_sel1;
    logic        fwd_enable, fwd_enable1, fwd_write, fwd_write1;
    logic [7:0]  fwd_addr, fwd_addr1;
    logic [31:0] fwd_wdata, fwd_wdata1;

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    // Slots answer with a pattern tied to the address.
    assign fwd_rdata = 32'hC0DE_0000 ^ {20'h0, paddr};

    sdhw_top #(.NUM_SLOTS(2), .CAP_RESET(CAPR)) dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .slot_irq(slot_irq), .irq_out(irq_out),
        .slot_cap(slot_cap), .slot_maxcur(slot_maxcur), .fwd_sel(fwd_sel),
        .fwd_enable(fwd_enable), .fwd_write(fwd_write), .fwd_addr(fwd_addr),
        .fwd_wdata(fwd_wdata), .fwd_rdata(fwd_rdata));

    sdhw_top #(.NUM_SLOTS(1), .CAP_RESET(CAPR)) dut1 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata1),
        .pready(pready1), .pslverr(pslverr1), .slot_irq(slot_irq), .irq_out(irq_out1),
        .slot_cap(slot_cap1), .slot_maxcur(slot_maxcur1), .fwd_sel(fwd_sel1),
        .fwd_enable(fwd_enable1), .fwd_write(fwd_write1), .fwd_addr(fwd_addr1),
        .fwd_wdata(fwd_wdata1), .fwd_rdata(fwd_rdata));

    // Bench model of the two-slot instance.
    logic [31:0] m_ctrl, m_debn, m_busc, m_wpol, m_cdet;
    logic [31:0] m_cap[2], m_mc[2];

    // Values captured in the access phase.
    logic [31:0] s_rd, s_rd1;
    logic        s_err, s_err1, s_wr;
    logic [1:0]  s_sel, s_sel1;
    logic [7:0]  s_addr;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctrl = 32'h0003_0000; m_debn = 32'h5; m_busc = 0; m_wpol = 0; m_cdet = 0;
        for (int n = 0; n < 2; n++) begin m_cap[n] = CAPR; m_mc[n] = 0; end
    endtask

    function automatic bit mdl_err(input logic [11:0] a, input logic [3:0] s);
        return (s != 4'hF) || (a >= 12'h300);
    endfunction

    function automatic logic [31:0] mdl_rd(input logic [11:0] a);
        if (a[11:8] == 4'h1 || a[11:8] == 4'h2) return 32'hC0DE_0000 ^ {20'h0, a};
        if (a[11:8] != 4'h0) return 32'h0;
        case (a[7:0])
            8'h00: return m_ctrl;
            8'h04: return m_debn;
            8'h08: return m_busc;
            8'h10: return m_cap[0];
            8'h18: return m_mc[0];
            8'h20: return m_cap[1];
            8'h28: return m_mc[1];
            8'hEC: return m_wpol;
            8'hF0: return m_cdet;
            8'hFC: return {30'h0, slot_irq};
            default: return 32'h0;
        endcase
    endfunction

    task automatic mdl_wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
        if (mdl_err(a, s) || a[11:8] != 4'h0) return;
        case (a[7:0])
            8'h00: m_ctrl = {d[31:1], 1'b0};
            8'h04: m_debn = d;
            8'h08: m_busc = d;
            8'h10: m_cap[0] = d;
            8'h18: m_mc[0] = d;
            8'h20: m_cap[1] = d;
            8'h28: m_mc[1] = d;
            8'hEC: m_wpol = d;
            8'hF0: m_cdet = d;
            default: ;
        endcase
    endtask

    // One APB transfer; outputs sampled in the access phase, away from the edge.
    task automatic apb(input bit wr, input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
        @(negedge clk);
        penable = 1'b1;
        #1;
        s_rd = prdata; s_err = pslverr; s_sel = fwd_sel; s_addr = fwd_addr; s_wr = fwd_write;
        s_rd1 = prdata1; s_err1 = pslverr1; s_sel1 = fwd_sel1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pstrb = 4'hF;
    endtask

    task automatic rd_check(input logic [11:0] a, input string req);
        apb(1'b0, a, 32'h0, 4'hF);
        chk(s_rd == mdl_rd(a), req, s_rd, mdl_rd(a));
        chk(s_err == mdl_err(a, 4'hF), req, s_err, mdl_err(a, 4'hF));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [11:0] offs[15];
        void'($urandom(32'd1234));
        offs = '{12'h000, 12'h004, 12'h008, 12'h010, 12'h018, 12'h020, 12'h028,
                 12'h0EC, 12'h0F0, 12'h0FC, 12'h040, 12'h104, 12'h2F8, 12'h300, 12'hFFC};
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(irq_out == 1'b0, "R1", irq_out, 0);
        chk(slot_cap == {CAPR, CAPR}, "R1", slot_cap, {CAPR, CAPR});
        chk(slot_maxcur == 64'h0, "R1", slot_maxcur, 0);
        rd_check(12'h000, "R1");
        chk(s_rd1 == 32'h0001_0000, "R1 one-slot ctrl", s_rd1, 32'h0001_0000);
        rd_check(12'h004, "R1");
        rd_check(12'h008, "R1");
        rd_check(12'h0EC, "R1");
        rd_check(12'h0F0, "R1");
        rd_check(12'h0FC, "R1");

        // R2 bit 0 of control word never stores
        apb(1'b1, 12'h000, 32'hFFFF_FFFF, 4'hF); mdl_wr(12'h000, 32'hFFFF_FFFF, 4'hF);
        apb(1'b0, 12'h000, 0, 4'hF);
        chk(s_rd == 32'hFFFF_FFFE, "R2", s_rd, 32'hFFFF_FFFE);

        // R3 plain storage
        apb(1'b1, 12'h0EC, 32'h1234_5678, 4'hF); mdl_wr(12'h0EC, 32'h1234_5678, 4'hF);
        rd_check(12'h0EC, "R3");

        // R4 alias registers drive the slot lanes
        apb(1'b1, 12'h010, 32'hAAAA_0001, 4'hF); mdl_wr(12'h010, 32'hAAAA_0001, 4'hF);
        apb(1'b1, 12'h028, 32'h5555_0002, 4'hF); mdl_wr(12'h028, 32'h5555_0002, 4'hF);
        chk(slot_cap[31:0] == 32'hAAAA_0001, "R4 cap lane0", slot_cap[31:0], 32'hAAAA_0001);
        chk(slot_maxcur[63:32] == 32'h5555_0002, "R4 mc lane1", slot_maxcur[63:32], 32'h5555_0002);
        rd_check(12'h010, "R4");

        // R8 partial strobe changes nothing
        apb(1'b1, 12'h008, 32'hDEAD_BEEF, 4'b0011);
        chk(s_err == 1'b1, "R8 err", s_err, 1);
        rd_check(12'h008, "R8");

        // R9 out of range
        apb(1'b1, 12'h400, 32'hDEAD_BEEF, 4'hF);
        chk(s_err == 1'b1 && s_sel == 2'b00, "R9 err", {s_err, s_sel}, 3'b100);
        rd_check(12'h300, "R9");

        // R11 unnamed local offset
        apb(1'b1, 12'h040, 32'hFFFF_FFFF, 4'hF);
        rd_check(12'h040, "R11");

        // R7 slot window pass-through
        apb(1'b0, 12'h1A4, 0, 4'hF);
        chk(s_sel == 2'b01 && s_addr == 8'hA4, "R7 sel/addr", {s_sel, s_addr}, {2'b01, 8'hA4});
        chk(s_rd == 32'hC0DE_01A4 && !s_err, "R7 rdata", s_rd, 32'hC0DE_01A4);
        apb(1'b1, 12'h23C, 32'h77, 4'hF);
        chk(s_sel == 2'b10 && s_wr, "R7 write", {s_sel, s_wr}, 3'b101);

        // R5/R6 interrupt timing
        @(negedge clk); slot_irq = 2'b10; #1;
        chk(irq_out == 1'b0, "R6 before edge", irq_out, 0);
        @(negedge clk); #1;
        chk(irq_out == 1'b1, "R6 after edge", irq_out, 1);
        chk(irq_out1 == 1'b0, "R10 irq", irq_out1, 0);
        rd_check(12'h0FC, "R5");
        chk(s_rd1 == 32'h0, "R10 status", s_rd1, 0);
        apb(1'b1, 12'h0FC, 32'h0, 4'hF);
        rd_check(12'h0FC, "R5 write ignored");
        @(negedge clk); slot_irq = 2'b00;
        @(negedge clk); #1;
        chk(irq_out == 1'b0, "R6 fall", irq_out, 0);

        // R10 single-slot instance
        apb(1'b1, 12'h020, 32'h1111_2222, 4'hF); mdl_wr(12'h020, 32'h1111_2222, 4'hF);
        apb(1'b0, 12'h020, 0, 4'hF);
        chk(s_rd1 == 32'h0 && !s_err1, "R10 alias", s_rd1, 0);
        chk(slot_cap1[63:32] == 32'h0, "R10 cap lane", slot_cap1[63:32], 0);
        apb(1'b0, 12'h210, 0, 4'hF);
        chk(s_rd1 == 32'h0 && !s_err1 && s_sel1 == 2'b00, "R10 window", {s_rd1, s_err1, s_sel1}, 0);

        // Random mix: R3 R4 R5 R8 R9 R11
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            logic [31:0] d;
            logic [3:0]  s;
            a = offs[$urandom_range(0, 14)];
            d = $urandom;
            s = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
            if ($urandom_range(0, 5) == 0) begin
                @(negedge clk); slot_irq = 2'($urandom);
            end
            if ($urandom_range(0, 1) == 0) begin
                apb(1'b1, a, d, s);
                chk(s_err == mdl_err(a, s), "R8/R9 random write err", s_err, mdl_err(a, s));
                mdl_wr(a, d, s);
            end else begin
                apb(1'b0, a, 0, s);
                if (mdl_err(a, s))
                    chk(s_err && s_rd == 0, "R8/R9 random read", {s_err, s_rd}, {1'b1, 32'h0});
                else
                    chk(!s_err && s_rd == mdl_rd(a), "R3/R4/R5 random read", s_rd, mdl_rd(a));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule